// File: doc/BRIEF.md
# Bus Acceptor Handshake Listener

This block is the listening half of the three-wire byte handshake used on an instrument bus with open-collector, active-low control lines. When enabled, it tells the talker it is ready by releasing the not-ready-for-data line. It then waits for the talker to signal valid data. It marks itself busy, takes the byte from the eight data lines, and releases the not-data-accepted line. Once the talker withdraws its data-valid signal, it asserts the data-accepted line again. Each completed cycle delivers one byte, with an optional end-of-message flag, on a one-cycle strobe.

The controller or the surrounding logic sets three inputs: whether the block is listening, whether it is taking commands (attention asserted), and whether the end-of-message line is captured. The four incoming control lines pass through a synchronizer chain before use. A transfer is abandoned in three cases: the interface-clear line is asserted, attention drops while commands are being received, or the talker leaves the data-valid line unchanged for longer than a programmable number of cycles. Each abandoned transfer raises a one-cycle abort strobe with a cause code.

The controller has six states. IDLE holds both drive lines asserted. The transition IDLE to READY happens when `listen_en` is high. READY releases the not-ready line. READY goes to BUSY when synchronized data-valid is low, or to ABORT on timeout. BUSY asserts both lines and captures the byte, then always moves to RELEASE. RELEASE releases the not-accepted line and pulses `rx_valid`, then always moves to WAIT_HI. WAIT_HI keeps the not-accepted line released. It returns to IDLE when data-valid goes high, or goes to ABORT on timeout. From READY, BUSY, RELEASE or WAIT_HI, an interface clear or a loss of attention goes straight to ABORT. ABORT pulses `abort_valid` and always returns to IDLE.

Top module: `gpib_listen_hs`

## Requirements
- R1: After reset, `nrfd_n` and `ndac_n` are both 0 (asserted) and `rx_valid` and `abort_valid` are 0. This state holds while `listen_en` is 0.
- R2: With `listen_en` high in IDLE, `nrfd_n` goes to 1 (released) one cycle later, while `ndac_n` stays 0.
- R3: When synchronized data-valid is seen low in READY, `nrfd_n` returns to 0. One cycle later `ndac_n` goes to 1 for as long as data-valid stays low. In the first cycle that `ndac_n` is 1, `rx_valid` is 1 for exactly one cycle. In that cycle `rx_byte` equals the bitwise inverse of `dio_n` as it was while data-valid was low.
- R4: After synchronized data-valid returns high, `ndac_n` goes back to 0. If `listen_en` is still high, `nrfd_n` is released one cycle later. Otherwise both lines stay asserted.
- R5: `nrfd_n` and `ndac_n` are never 1 at the same time.
- R6: With `eoi_cap_en` = 1, `rx_eoi` is 1 exactly when `eoi_n` was low together with the byte. With `eoi_cap_en` = 0, `rx_eoi` is 0.
- R7: In READY, BUSY, RELEASE or WAIT_HI, `ifc_n` = 0 ends the transfer. `abort_valid` pulses for one cycle with `abort_code` = 2'b01, and both drive lines are then asserted.
- R8: With `cmd_mode` = 1, `atn_n` = 1 in an active state ends the transfer with `abort_code` = 2'b10. If interface clear arrives in the same cycle, it wins and the code is 2'b01.
- R9: If the block spends `timeout_lim` cycles in READY or WAIT_HI without data-valid changing, it aborts with `abort_code` = 2'b11. A `timeout_lim` of 0 disables the timeout.
- R10: `dav_n`, `eoi_n`, `atn_n` and `ifc_n` are synchronized. A change on `dav_n` first affects the drive lines after the third rising clock edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| listen_en | input | 1 | Start a new handshake cycle from IDLE while high |
| cmd_mode | input | 1 | Receiving commands; attention release aborts |
| eoi_cap_en | input | 1 | Capture end-of-message with each byte |
| timeout_lim | input | CNT_W | Cycles allowed waiting for data-valid to change; 0 disables |
| dav_n | input | 1 | Data-valid line level, active low |
| eoi_n | input | 1 | End-of-message line level, active low |
| atn_n | input | 1 | Attention line level, active low |
| ifc_n | input | 1 | Interface-clear line level, active low |
| dio_n | input | DATA_W | Data lines, active low |
| nrfd_n | output | 1 | Not-ready-for-data drive level, 0 asserts |
| ndac_n | output | 1 | Not-data-accepted drive level, 0 asserts |
| rx_byte | output | DATA_W | Received byte |
| rx_eoi | output | 1 | End-of-message received with the byte |
| rx_valid | output | 1 | One-cycle strobe: byte and flag valid |
| abort_valid | output | 1 | One-cycle strobe: transfer abandoned |
| abort_code | output | 2 | Abort cause: 01 clear, 10 attention lost, 11 timeout |

## Verification
The assertions watch, on every cycle, the ordering rules between the two drive lines. They check that both lines are never released together and that the not-accepted release coincides with the byte strobe. They also check that a strobe only follows a cycle with both lines asserted, that a ready release is preceded by the enable, and that an abort always returns to both lines asserted. The bench scenarios show the rest: the captured byte and flag values, the three-edge synchronizer latency, the exact timeout length in both waiting states, the abort cause codes and their priority, and the behaviour when the enable is dropped mid-transfer.

// File: rtl/gpib_lhs_pkg.sv
package gpib_lhs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READY   = 3'd1,
        ST_BUSY    = 3'd2,
        ST_RELEASE = 3'd3,
        ST_WAIT_HI = 3'd4,
        ST_ABORT   = 3'd5
    } lhs_state_e;

    typedef enum logic [1:0] {
        ABORT_NONE = 2'd0,
        ABORT_IFC  = 2'd1,
        ABORT_ATN  = 2'd2,
        ABORT_TIME = 2'd3
    } lhs_abort_e;

endpackage

// File: rtl/lhs_sync.sv
module lhs_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lhs_wait_timer.sv
module lhs_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [CNT_W-1:0] lim,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (run && hold)  cnt_q <= cnt_q + CNT_W'(1);
        else                   cnt_q <= '0;
    end

    assign expired = run && (lim != '0) && (cnt_q == lim - CNT_W'(1));
endmodule

// File: rtl/lhs_ctrl.sv
module lhs_ctrl
    import gpib_lhs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen_en,
    input  logic              cmd_mode,
    input  logic              eoi_cap_en,
    input  logic              dav_s,
    input  logic              eoi_s,
    input  logic              atn_s,
    input  logic              ifc_s,
    input  logic [DATA_W-1:0] dio_n,
    input  logic              tmo_expired,
    output logic              wait_run,
    output logic              wait_hold,
    output logic              nrfd_n,
    output logic              ndac_n,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_eoi,
    output logic              rx_valid,
    output logic              abort_valid,
    output logic [1:0]        abort_code
);
    lhs_state_e  state_q, state_d;
    lhs_abort_e  cause_d, cause_q;
    logic        active;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and abort cause
    always_comb begin
        state_d = state_q;
        cause_d = ABORT_NONE;
        active  = (state_q == ST_READY) || (state_q == ST_BUSY) ||
                  (state_q == ST_RELEASE) || (state_q == ST_WAIT_HI);
        if (active && !ifc_s) begin
            state_d = ST_ABORT;
            cause_d = ABORT_IFC;
        end else if (active && cmd_mode && atn_s) begin
            state_d = ST_ABORT;
            cause_d = ABORT_ATN;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (listen_en) state_d = ST_READY;
                ST_READY: begin
                    if (!dav_s) state_d = ST_BUSY;
                    else if (tmo_expired) begin
                        state_d = ST_ABORT;
                        cause_d = ABORT_TIME;
                    end
                end
                ST_BUSY:    state_d = ST_RELEASE;
                ST_RELEASE: state_d = ST_WAIT_HI;
                ST_WAIT_HI: begin
                    if (dav_s) state_d = ST_IDLE;
                    else if (tmo_expired) begin
                        state_d = ST_ABORT;
                        cause_d = ABORT_TIME;
                    end
                end
                ST_ABORT:   state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        nrfd_n      = 1'b0;
        ndac_n      = 1'b0;
        rx_valid    = 1'b0;
        abort_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_READY:   nrfd_n = 1'b1;
            ST_BUSY:    ;
            ST_RELEASE: begin
                ndac_n   = 1'b1;
                rx_valid = 1'b1;
            end
            ST_WAIT_HI: ndac_n = 1'b1;
            ST_ABORT:   abort_valid = 1'b1;
            default:    ;
        endcase
    end

    assign wait_run  = (state_q == ST_READY) || (state_q == ST_WAIT_HI);
    assign wait_hold = (state_d == state_q);

    // byte capture and abort cause hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
            rx_eoi  <= 1'b0;
            cause_q <= ABORT_NONE;
        end else begin
            if (state_q == ST_BUSY) begin
                rx_byte <= ~dio_n;
                rx_eoi  <= eoi_cap_en & ~eoi_s;
            end
            if (state_d == ST_ABORT && state_q != ST_ABORT) cause_q <= cause_d;
        end
    end

    assign abort_code = cause_q;
endmodule

// File: rtl/gpib_listen_hs.sv
module gpib_listen_hs #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              listen_en,
    input  logic              cmd_mode,
    input  logic              eoi_cap_en,
    input  logic [CNT_W-1:0]  timeout_lim,
    input  logic              dav_n,
    input  logic              eoi_n,
    input  logic              atn_n,
    input  logic              ifc_n,
    input  logic [DATA_W-1:0] dio_n,
    output logic              nrfd_n,
    output logic              ndac_n,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_eoi,
    output logic              rx_valid,
    output logic              abort_valid,
    output logic [1:0]        abort_code
);
    localparam int LINES = 4;

    logic [LINES-1:0] lines_s;
    logic             tmo_expired, wait_run, wait_hold;

    lhs_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dav_n, eoi_n, atn_n, ifc_n}),
        .q     (lines_s)
    );

    lhs_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .hold    (wait_hold),
        .lim     (timeout_lim),
        .expired (tmo_expired)
    );

    lhs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .listen_en   (listen_en),
        .cmd_mode    (cmd_mode),
        .eoi_cap_en  (eoi_cap_en),
        .dav_s       (lines_s[3]),
        .eoi_s       (lines_s[2]),
        .atn_s       (lines_s[1]),
        .ifc_s       (lines_s[0]),
        .dio_n       (dio_n),
        .tmo_expired (tmo_expired),
        .wait_run    (wait_run),
        .wait_hold   (wait_hold),
        .nrfd_n      (nrfd_n),
        .ndac_n      (ndac_n),
        .rx_byte     (rx_byte),
        .rx_eoi      (rx_eoi),
        .rx_valid    (rx_valid),
        .abort_valid (abort_valid),
        .abort_code  (abort_code)
    );
endmodule

// File: rtl/gpib_listen_hs_chk.sv
module gpib_listen_hs_chk (
    input logic clk,
    input logic rst_n,
    input logic listen_en,
    input logic nrfd_n,
    input logic ndac_n,
    input logic rx_valid,
    input logic abort_valid
);
    // R5
    both_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nrfd_n && ndac_n));

    // R3
    accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ndac_n) |-> rx_valid);

    // R3
    busy_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!nrfd_n && !ndac_n));

    // R2
    ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nrfd_n) |-> $past(listen_en));

    // R7
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_valid |=> (!nrfd_n && !ndac_n && !abort_valid));

    // R8
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, abort_valid}));
endmodule

bind gpib_listen_hs gpib_listen_hs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .listen_en   (listen_en),
    .nrfd_n      (nrfd_n),
    .ndac_n      (ndac_n),
    .rx_valid    (rx_valid),
    .abort_valid (abort_valid)
);

// File: tb/tb_gpib_listen_hs.sv
module tb_gpib_listen_hs;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          listen_en, cmd_mode, eoi_cap_en;
    logic [CW-1:0] timeout_lim;
    logic          dav_n, eoi_n, atn_n, ifc_n;
    logic [7:0]    dio_n;
    logic          nrfd_n, ndac_n, rx_eoi, rx_valid, abort_valid;
    logic [7:0]    rx_byte;
    logic [1:0]    abort_code;

    always #10 clk = ~clk;

    gpib_listen_hs #(.DATA_W(8), .CNT_W(CW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .listen_en(listen_en), .cmd_mode(cmd_mode),
        .eoi_cap_en(eoi_cap_en), .timeout_lim(timeout_lim), .dav_n(dav_n),
        .eoi_n(eoi_n), .atn_n(atn_n), .ifc_n(ifc_n), .dio_n(dio_n),
        .nrfd_n(nrfd_n), .ndac_n(ndac_n), .rx_byte(rx_byte), .rx_eoi(rx_eoi),
        .rx_valid(rx_valid), .abort_valid(abort_valid), .abort_code(abort_code)
    );

    int total = 0, bad = 0;
    int vcount = 0, acount = 0;
    int last_byte = 0, last_eoi = 0, last_code = 0;

    // reference model: phase 0 idle,1 ready,2 busy,3 release,4 wait-high,5 abort
    int m_ph = 0, m_wcnt = 0, m_code = 0, m_byte = 0, m_eoi = 0;
    int q_dav[2], q_eoi[2], q_atn[2], q_ifc[2];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        int nx, d2, e2, a2, i2;
        bit act;
        if (!rst_n) begin
            m_ph = 0; m_wcnt = 0; m_code = 0; m_byte = 0; m_eoi = 0;
            for (int k = 0; k < 2; k++) begin
                q_dav[k] = 1; q_eoi[k] = 1; q_atn[k] = 1; q_ifc[k] = 1;
            end
            return;
        end
        d2 = q_dav[1]; e2 = q_eoi[1]; a2 = q_atn[1]; i2 = q_ifc[1];
        act = (m_ph >= 1 && m_ph <= 4);
        nx = m_ph;
        if (act && i2 == 0) begin nx = 5; m_code = 1; end
        else if (act && cmd_mode && a2 == 1) begin nx = 5; m_code = 2; end
        else begin
            case (m_ph)
                0: nx = listen_en ? 1 : 0;
                1: if (d2 == 0) nx = 2;
                   else if (timeout_lim != 0 && m_wcnt == int'(timeout_lim) - 1) begin nx = 5; m_code = 3; end
                2: nx = 3;
                3: nx = 4;
                4: if (d2 == 1) nx = 0;
                   else if (timeout_lim != 0 && m_wcnt == int'(timeout_lim) - 1) begin nx = 5; m_code = 3; end
                default: nx = 0;
            endcase
        end
        if (m_ph == 2) begin
            m_byte = int'(~dio_n);
            m_eoi  = (eoi_cap_en && e2 == 0) ? 1 : 0;
        end
        if ((m_ph == 1 || m_ph == 4) && nx == m_ph) m_wcnt++;
        else m_wcnt = 0;
        m_ph = nx;
        q_dav[1] = q_dav[0]; q_dav[0] = dav_n;
        q_eoi[1] = q_eoi[0]; q_eoi[0] = eoi_n;
        q_atn[1] = q_atn[0]; q_atn[0] = atn_n;
        q_ifc[1] = q_ifc[0]; q_ifc[0] = ifc_n;
    endtask

    task automatic compare();
        int en, ed;
        en = (m_ph == 1) ? 1 : 0;
        ed = (m_ph == 3 || m_ph == 4) ? 1 : 0;
        check(nrfd_n == en, "R2 nrfd_n per cycle", nrfd_n, en);
        check(ndac_n == ed, "R4 ndac_n per cycle", ndac_n, ed);
        check(rx_valid == (m_ph == 3), "R3 rx_valid per cycle", rx_valid, m_ph == 3);
        check(abort_valid == (m_ph == 5), "R7 abort_valid per cycle", abort_valid, m_ph == 5);
        if (m_ph == 3) begin
            check(rx_byte == m_byte[7:0], "R3 rx_byte", rx_byte, m_byte);
            check(rx_eoi == m_eoi[0], "R6 rx_eoi", rx_eoi, m_eoi);
        end
        if (m_ph == 5)
            check(abort_code == m_code[1:0], "R9 abort_code per cycle", abort_code, m_code);
        if (rx_valid) begin vcount++; last_byte = rx_byte; last_eoi = rx_eoi; end
        if (abort_valid) begin acount++; last_code = abort_code; end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wait_ready();
        for (int n = 0; n < 60 && nrfd_n !== 1'b1; n++) step();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit e, input bit drop_en);
        int v0;
        v0 = vcount;
        wait_ready();
        dio_n = ~b; eoi_n = ~e; dav_n = 1'b0;
        step(); check(nrfd_n == 1'b1, "R10 edge 1 no response", nrfd_n, 1);
        step(); check(nrfd_n == 1'b1, "R10 edge 2 no response", nrfd_n, 1);
        step(); check(nrfd_n == 1'b0, "R10 busy after edge 3", nrfd_n, 0);
        for (int n = 0; n < 60 && ndac_n !== 1'b1; n++) step();
        check(rx_valid == 1'b1, "R3 strobe with ndac release", rx_valid, 1);
        check(rx_byte == b, "R3 byte value", rx_byte, b);
        check(rx_eoi == (e & eoi_cap_en), "R6 eoi flag", rx_eoi, e & eoi_cap_en);
        if (drop_en) listen_en = 1'b0;
        dav_n = 1'b1; dio_n = 8'hFF; eoi_n = 1'b1;
        for (int n = 0; n < 60 && ndac_n !== 1'b0; n++) step();
        check(vcount == v0 + 1, "R3 one strobe per byte", vcount, v0 + 1);
    endtask

    initial begin
        int a0;
        rst_n = 1'b0; listen_en = 1'b0; cmd_mode = 1'b0; eoi_cap_en = 1'b1;
        timeout_lim = CW'(40); dav_n = 1'b1; eoi_n = 1'b1; atn_n = 1'b1;
        ifc_n = 1'b1; dio_n = 8'hFF;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1
        check(nrfd_n == 0 && ndac_n == 0, "R1 lines asserted after reset", {nrfd_n, ndac_n}, 0);
        check(rx_valid == 0 && abort_valid == 0, "R1 no strobes after reset", {rx_valid, abort_valid}, 0);
        repeat (5) step();
        check(nrfd_n == 0, "R1 idle without enable", nrfd_n, 0);

        // R2
        listen_en = 1'b1;
        step();
        check(nrfd_n == 1 && ndac_n == 0, "R2 ready one cycle after enable", {nrfd_n, ndac_n}, 2);

        send_byte(8'hA5, 1'b0, 1'b0);
        send_byte(8'h00, 1'b1, 1'b0);
        send_byte(8'hFF, 1'b0, 1'b0);
        // R4 re-release of ready after completed cycle
        step();
        check(nrfd_n == 1, "R4 ready again with enable", nrfd_n, 1);
        // R6 capture disabled
        eoi_cap_en = 1'b0;
        send_byte(8'h3C, 1'b1, 1'b0);
        check(last_eoi == 0, "R6 eoi ignored when capture off", last_eoi, 0);
        eoi_cap_en = 1'b1;
        // R4 enable dropped
        send_byte(8'h5A, 1'b1, 1'b1);
        repeat (5) step();
        check(nrfd_n == 0 && ndac_n == 0, "R4 stays idle when enable low", {nrfd_n, ndac_n}, 0);

        // R7 interface clear
        listen_en = 1'b1; a0 = acount;
        wait_ready();
        ifc_n = 1'b0;
        repeat (4) step();
        check(acount > a0 && last_code == 1, "R7 ifc abort code", last_code, 1);
        listen_en = 1'b0; ifc_n = 1'b1;
        repeat (6) step();
        check(nrfd_n == 0 && ndac_n == 0, "R7 idle after abort", {nrfd_n, ndac_n}, 0);

        // R8 command mode
        cmd_mode = 1'b1; atn_n = 1'b0; listen_en = 1'b1;
        repeat (3) step();
        send_byte(8'h3F, 1'b0, 1'b0);
        wait_ready();
        a0 = acount; atn_n = 1'b1;
        for (int n = 0; n < 10 && acount == a0; n++) step();
        check(last_code == 2, "R8 attention loss code", last_code, 2);
        listen_en = 1'b0; atn_n = 1'b0;
        repeat (6) step();
        // R8 priority
        listen_en = 1'b1;
        wait_ready();
        a0 = acount; atn_n = 1'b1; ifc_n = 1'b0;
        for (int n = 0; n < 10 && acount == a0; n++) step();
        check(last_code == 1, "R8 clear wins over attention", last_code, 1);
        listen_en = 1'b0; ifc_n = 1'b1; atn_n = 1'b1; cmd_mode = 1'b0;
        repeat (6) step();

        // R9 timeout in ready
        timeout_lim = CW'(20); listen_en = 1'b1; a0 = acount;
        wait_ready();
        repeat (19) step();
        check(nrfd_n == 1 && acount == a0, "R9 still ready before limit", nrfd_n, 1);
        step();
        check(abort_valid == 1 && abort_code == 2'b11, "R9 timeout in ready", abort_code, 3);
        listen_en = 1'b0;
        repeat (4) step();
        // R9 timeout in wait-high
        timeout_lim = CW'(10); listen_en = 1'b1;
        wait_ready();
        dio_n = 8'h00; dav_n = 1'b0;
        for (int n = 0; n < 60 && ndac_n !== 1'b1; n++) step();
        repeat (10) step();
        check(ndac_n == 1 && abort_valid == 0, "R9 still waiting before limit", ndac_n, 1);
        step();
        check(abort_valid == 1 && abort_code == 2'b11, "R9 timeout in wait-high", abort_code, 3);
        listen_en = 1'b0;
        step();
        dav_n = 1'b1; dio_n = 8'hFF;
        repeat (4) step();
        // R9 disabled
        timeout_lim = '0; listen_en = 1'b1; a0 = acount;
        repeat (100) step();
        check(acount == a0 && nrfd_n == 1, "R9 zero limit disables timeout", acount, a0);
        listen_en = 1'b0;
        repeat (3) step();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule